// File: doc/BRIEF.md
# Floating-Point Status and Exception Control

This block keeps the control/status word that sits beside a floating-point arithmetic unit. The word holds five fields:

- a two-bit rounding selector;
- five sticky flag bits;
- five trap-enable bits;
- five cause bits;
- one denormal-flush bit.

The block does no arithmetic. It only records what each operation reported and tells the datapath how to round and whether to flush denormals.

When an operation finishes, the datapath pulses `op_done_i`. With that pulse it presents the five raw IEEE exception indications on `exc_i`, and it raises `op_rsqrt_i` if the operation was the approximate reciprocal square root. On that edge the block does three things:

- It replaces the cause field with the new indications.
- It ORs the new cause bits into the sticky flags.
- It decides whether a floating-point trap is due. A trap is due when any cause bit has its matching enable bit set.

A trap appears as a one-cycle request carrying the fixed vector code 0x120. Software-side writes load the whole word through a fixed writable-bit mask.

Top module: `fp_status_ctrl`

## Requirements
- R1: After reset, `csr_o`, `round_zero_o`, `flush_zero_o`, `trap_req_o` and `trap_code_o` are all zero.
- R2: On each operation end that is not accepted together with a write, the cause field `csr_o[16:12]` is rebuilt from `exc_i`. The bit order is inexact=bit0, underflow=bit1, overflow=bit2, divide-by-zero=bit3, invalid=bit4, mapped to csr bits 12..16. With no indication present, the cause field becomes zero.
- R3: On an accepted operation end, the new cause bits are ORed into the flag field `csr_o[6:2]` (same bit order). An operation never clears a flag.
- R4: `trap_req_o` is high for exactly the cycle after an accepted operation end whose new cause ANDed with the enable field `csr_o[11:7]` is non-zero. While it is high, `trap_code_o` equals 0x120; otherwise `trap_code_o` is 0.
- R5: A write (`wr_en_i`) loads `wr_data_i & 32'h0005_FFFF` into the word. Bits 17 and 31:19 always read zero.
- R6: `round_zero_o` is high exactly when the rounding field `csr_o[1:0]` equals 2'b01, which selects truncation. Every other code selects round-to-nearest-even.
- R7: `flush_zero_o` equals the denormal bit `csr_o[18]`.
- R8: For an operation with `op_rsqrt_i` high and `exc_i` all zero, inexact (bit0) is forced in the cause. If any indication is present, the cause equals `exc_i` unchanged.
- R9: When `wr_en_i` and `op_done_i` are high in the same cycle, the write takes effect, the operation's update is dropped, and no trap is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Load the status word |
| wr_data_i | input | 32 | Value to load (masked) |
| op_done_i | input | 1 | Floating-point operation finished this cycle |
| op_rsqrt_i | input | 1 | The finishing operation is approximate reciprocal square root |
| exc_i | input | 5 | Raw indications {V,Z,O,U,I} |
| csr_o | output | 32 | Status word contents |
| round_zero_o | output | 1 | Datapath rounds toward zero when high |
| flush_zero_o | output | 1 | Datapath flushes denormals when high |
| trap_req_o | output | 1 | One-cycle floating-point trap request |
| trap_code_o | output | 12 | Trap vector code, 0x120 while requesting |

## Verification
Every result of a write or an operation end is due one rising edge later:

- the status word;
- the two datapath controls, which follow the word combinationally;
- the trap pulse and its code.

The bench applies each stimulus at a falling edge. It advances a behavioural model of the word by one step. At the next falling edge it compares every output field against that model, so each comparison lands exactly one register stage after its cause. Idle cycles between operations are compared too, which confirms that the trap pulse has dropped and that the flags have held.

// File: rtl/fp_status_pkg.sv
package fp_status_pkg;
  localparam int          EXC_W     = 5;
  localparam int          CSR_W     = 32;
  localparam int          RM_LSB    = 0;
  localparam int          RM_W      = 2;
  localparam int          FLAG_LSB  = 2;
  localparam int          EN_LSB    = FLAG_LSB + EXC_W;
  localparam int          CAUSE_LSB = EN_LSB + EXC_W;
  localparam int          DN_BIT    = 18;
  localparam int          CODE_W    = 12;
  localparam logic [31:0] WR_MASK   = 32'h0005_FFFF;
  localparam logic [1:0]  RM_RTZ    = 2'b01;
  localparam logic [11:0] TRAP_CODE = 12'h120;
  localparam int          EXC_INX   = 0;
endpackage

// File: rtl/fp_cause_gen.sv
module fp_cause_gen
  import fp_status_pkg::*;
#(
  parameter int W = EXC_W
) (
  input  logic [W-1:0] exc_i,
  input  logic         rsqrt_i,
  output logic [W-1:0] cause_o
);
  always_comb begin
    cause_o = exc_i;
    // approximation result is always inexact unless something stronger fired
    if (rsqrt_i && (exc_i == '0)) cause_o[EXC_INX] = 1'b1;
  end
endmodule

// File: rtl/fp_csr_reg.sv
module fp_csr_reg
  import fp_status_pkg::*;
#(
  parameter int          W    = CSR_W,
  parameter int          EW   = EXC_W,
  parameter logic [31:0] MASK = WR_MASK
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          op_en_i,
  input  logic [EW-1:0] cause_i,
  output logic [W-1:0]  csr_o
);
  logic [W-1:0] csr_q;
  logic [EW-1:0] flags;
  assign flags = csr_q[FLAG_LSB +: EW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_q <= '0;
    end else if (wr_en_i) begin
      csr_q <= wr_data_i & MASK[W-1:0];
    end else if (op_en_i) begin
      csr_q[CAUSE_LSB +: EW] <= cause_i;
      csr_q[FLAG_LSB +: EW]  <= flags | cause_i;
    end
  end

  assign csr_o = csr_q;

  assert_flags_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((csr_q[FLAG_LSB +: EW] & $past(csr_q[FLAG_LSB +: EW])) == $past(csr_q[FLAG_LSB +: EW])));
  assert_cause_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_en_i && !wr_en_i && cause_i == '0) |=> (csr_q[CAUSE_LSB +: EW] == '0));
  assert_write_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ((csr_q & ~MASK[W-1:0]) == '0));
endmodule

// File: rtl/fp_trap_gen.sv
module fp_trap_gen
  import fp_status_pkg::*;
#(
  parameter int EW = EXC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_en_i,
  input  logic [EW-1:0] cause_i,
  input  logic [EW-1:0] enable_i,
  output logic          trap_o
);
  logic trap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trap_q <= 1'b0;
    else         trap_q <= op_en_i && ((cause_i & enable_i) != '0);
  end
  assign trap_o = trap_q;

  assert_trap_needs_op_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_q |-> $past(op_en_i));
endmodule

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl
  import fp_status_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  input  logic        op_done_i,
  input  logic        op_rsqrt_i,
  input  logic [4:0]  exc_i,
  output logic [31:0] csr_o,
  output logic        round_zero_o,
  output logic        flush_zero_o,
  output logic        trap_req_o,
  output logic [11:0] trap_code_o
);
  logic [EXC_W-1:0] cause_n;
  logic             op_en;
  logic [CSR_W-1:0] csr;
  logic             trap;

  // a concurrent write wins over the operation update
  assign op_en = op_done_i && !wr_en_i;

  fp_cause_gen #(.W(EXC_W)) i_cause (
    .exc_i   (exc_i),
    .rsqrt_i (op_rsqrt_i),
    .cause_o (cause_n)
  );

  fp_csr_reg #(.W(CSR_W), .EW(EXC_W), .MASK(WR_MASK)) i_csr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .op_en_i   (op_en),
    .cause_i   (cause_n),
    .csr_o     (csr)
  );

  fp_trap_gen #(.EW(EXC_W)) i_trap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_en_i  (op_en),
    .cause_i  (cause_n),
    .enable_i (csr[EN_LSB +: EXC_W]),
    .trap_o   (trap)
  );

  assign csr_o        = csr;
  assign round_zero_o = (csr[RM_LSB +: RM_W] == RM_RTZ);
  assign flush_zero_o = csr[DN_BIT];
  assign trap_req_o   = trap;
  assign trap_code_o  = trap ? TRAP_CODE : '0;

  assert_trap_matches_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o |-> ((csr_o[CAUSE_LSB +: EXC_W] & $past(csr_o[EN_LSB +: EXC_W])) != '0));
  assert_write_beats_op_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !trap_req_o);
endmodule

// File: tb/test_fp_status_ctrl.sv
module test_fp_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        op_done = 1'b0;
  logic        op_rsqrt = 1'b0;
  logic [4:0]  exc = '0;
  logic [31:0] csr;
  logic        rz, fz, trap;
  logic [11:0] code;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] m_csr = '0;
  bit          m_trap = 0;

  always #10 clk = ~clk;

  fp_status_ctrl i_fp_status_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .op_done_i(op_done), .op_rsqrt_i(op_rsqrt), .exc_i(exc),
    .csr_o(csr), .round_zero_o(rz), .flush_zero_o(fz),
    .trap_req_o(trap), .trap_code_o(code)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "cause", {27'd0, csr[16:12]}, {27'd0, m_csr[16:12]});
    chk(tag, "flags", {27'd0, csr[6:2]},   {27'd0, m_csr[6:2]});
    chk(tag, "word",  csr, m_csr);
    chk(tag, "round_zero", {31'd0, rz}, {31'd0, m_csr[1:0] == 2'b01});
    chk(tag, "flush_zero", {31'd0, fz}, {31'd0, m_csr[18]});
    chk(tag, "trap", {31'd0, trap}, {31'd0, m_trap});
    chk(tag, "code", {20'd0, code}, m_trap ? 32'h120 : 32'h0);
  endtask

  // drive at falling edge, advance model one step, compare at next falling edge
  task automatic step(string tag, bit w, logic [31:0] d, bit op, bit rs, logic [4:0] e);
    logic [4:0] c;
    wr_en = w; wr_data = d; op_done = op; op_rsqrt = rs; exc = e;
    m_trap = 0;
    if (w) begin
      m_csr = d & 32'h0005_FFFF;
    end else if (op) begin
      c = (rs && e == 5'd0) ? 5'b00001 : e;
      m_trap = (c & m_csr[11:7]) != 5'd0;
      m_csr[16:12] = c;
      m_csr[6:2]   = m_csr[6:2] | c;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    compare("R1");
    rst_ni = 1'b1;
    @(negedge clk);
    compare("R1");
    step("R5", 1, 32'hFFFF_FFFF, 0, 0, 0);
    step("R7", 1, 32'h0004_0000, 0, 0, 0);
    step("R6", 1, 32'h0000_0001, 0, 0, 0);
    step("R6", 1, 32'h0000_0002, 0, 0, 0);
    step("R2", 0, 0, 1, 0, 5'b10000);
    step("R3", 0, 0, 1, 0, 5'b00100);
    step("R2", 0, 0, 1, 0, 5'b00000);
    step("R3", 0, 0, 0, 0, 5'b11111);
    step("R4", 1, 32'h0000_0400, 0, 0, 0);
    step("R4", 0, 0, 1, 0, 5'b01000);
    step("R4", 0, 0, 0, 0, 0);
    step("R4", 0, 0, 1, 0, 5'b10001);
    step("R4", 0, 0, 1, 0, 5'b01000);
    step("R4", 0, 0, 1, 0, 5'b01000);
    step("R8", 1, 32'h0000_0080, 0, 0, 0);
    step("R8", 0, 0, 1, 1, 5'b00000);
    step("R8", 0, 0, 1, 1, 5'b00100);
    step("R9", 1, 32'h0000_0F80, 1, 0, 5'b11111);
    step("R9", 0, 0, 0, 0, 0);
    for (int i = 0; i < 300; i++) begin
      bit w;
      w = ($urandom % 8) == 0;
      step("R2_R3_R4", w, $urandom, ($urandom % 3) != 0, ($urandom % 4) == 0,
           (($urandom % 3) == 0) ? 5'd0 : 5'($urandom));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule